// File: doc/BRIEF.md
# Execute Unit: Shared Adder, Flag Register and Branch Resolution

This block is the execute stage of a single-cycle processor. Each cycle it receives the decoded opcode and function code of one instruction, together with the two register operands, the instruction's constant word, the fall-through address and the value read from memory. From these inputs it selects the operands for one shared ALU and produces the result word. It keeps a three-bit flag register that only valid arithmetic/logic instructions write. It resolves conditional jumps from the stored flags and the function code, and it chooses the next program counter.

The ALU computes data results, load/store effective addresses and stack-pointer adjustments. The operand selector picks what feeds it: a register, the constant, a zero, or a stack step of plus or minus one word. Everything is combinational except the flag register, which loads on the rising clock edge. The register file, the data memory and the program counter register sit outside this block.

Top module: `exec_unit`

## Requirements
- R1: Opcode 6 is arithmetic/logic. Its result is b OP a, with function code 0 = add (b+a), 1 = subtract (b-a), 2 = bitwise and, 3 = bitwise xor.
- R2: Opcode 2 (register copy) gives result a. Opcode 3 (immediate load) gives result c.
- R3: Opcode 4 (store) and opcode 5 (load) give the address b+c, modulo 2^W.
- R4: Opcode 10 (push) and opcode 8 (call) give b minus W/8. Opcode 11 (pop) and opcode 9 (return) give b plus W/8.
- R5: The result is zero for opcodes 0, 1 and 7, for opcodes 12 to 15, and for opcode 6 with a function code above 3.
- R6: On the rising edge after opcode 6 with function code 0 to 3, the flags load as follows: Z = (result is zero), S = (result MSB), O = signed overflow of the add or subtract. O is 0 after and or xor.
- R7: No other opcode, and no opcode 6 with a function code above 3, changes the flags.
- R8: While rst_ni is low the flags are Z=1, S=0, O=0.
- R9: For opcode 7 the jump is taken according to the function code: 0 always; 1 if (S^O)|Z; 2 if S^O; 3 if Z; 4 if !Z; 5 if !(S^O); 6 if !(S^O)&!Z. Function codes 7 to 15 are never taken, and take_o is 0 for every other opcode.
- R10: next_pc_o is c for opcode 8 and for a taken jump, the memory value m for opcode 9, and the fall-through address p otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opc_i | input | 4 | Instruction opcode |
| fn_i | input | 4 | Function code (ALU operation or jump condition) |
| a_val_i | input | W | First register operand |
| b_val_i | input | W | Second register operand (base or stack pointer) |
| c_val_i | input | W | Constant word (immediate, displacement or target) |
| p_val_i | input | W | Fall-through address |
| m_val_i | input | W | Value read from memory (return address) |
| e_val_o | output | W | ALU result |
| take_o | output | 1 | Jump taken |
| next_pc_o | output | W | Selected next program counter |

## Verification
The assertions assume that opcode and function code are stable and known at each rising edge. They also assume that a and b are known whenever an arithmetic instruction is presented, because the zero, sign and overflow properties compare the flags to the result sampled one edge earlier. The bench changes every input only at the falling edge and holds it across the following rising edge. It keeps all operands defined from reset onward. After any flag-setting instruction, it leaves at least one edge before the next jump, so each flag check reads settled state.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam logic [3:0] OP_NOP   = 4'h0;
  localparam logic [3:0] OP_HALT  = 4'h1;
  localparam logic [3:0] OP_MOVRR = 4'h2;
  localparam logic [3:0] OP_MOVIR = 4'h3;
  localparam logic [3:0] OP_STORE = 4'h4;
  localparam logic [3:0] OP_LOAD  = 4'h5;
  localparam logic [3:0] OP_ARITH = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

  localparam logic [3:0] FN_ALU_MAX  = 4'd3;
  localparam logic [3:0] FN_JMP_MAX  = 4'd6;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_XOR = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic ovf;
  } cc_t;

  localparam cc_t CC_RESET = '{zf: 1'b1, sf: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/exec_opsel.sv
module exec_opsel
  import exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   opc_i,
  input  logic [3:0]   fn_i,
  input  logic [W-1:0] a_val_i,
  input  logic [W-1:0] b_val_i,
  input  logic [W-1:0] c_val_i,
  output logic [W-1:0] alu_a_o,
  output logic [W-1:0] alu_b_o,
  output alu_fn_e      alu_fn_o,
  output logic         cc_we_o
);

  localparam logic [W-1:0] STEP     = W'(W / 8);
  localparam logic [W-1:0] STEP_NEG = ~STEP + 1'b1;

  logic arith_ok;
  assign arith_ok = (opc_i == OP_ARITH) && (fn_i <= FN_ALU_MAX);

  always_comb begin
    alu_a_o  = '0;
    alu_b_o  = '0;
    alu_fn_o = ALU_ADD;
    unique case (opc_i)
      OP_ARITH: if (arith_ok) begin
        alu_a_o  = a_val_i;
        alu_b_o  = b_val_i;
        alu_fn_o = alu_fn_e'(fn_i[1:0]);
      end
      OP_MOVRR: alu_a_o = a_val_i;
      OP_MOVIR: alu_a_o = c_val_i;
      OP_STORE, OP_LOAD: begin
        alu_a_o = c_val_i;
        alu_b_o = b_val_i;
      end
      OP_PUSH, OP_CALL: begin
        alu_a_o = STEP_NEG;
        alu_b_o = b_val_i;
      end
      OP_POP, OP_RET: begin
        alu_a_o = STEP;
        alu_b_o = b_val_i;
      end
      default: ;
    endcase
  end

  assign cc_we_o = arith_ok;

endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] res_o,
  output cc_t          cc_o
);

  localparam int MSB = W - 1;

  logic ovf;

  always_comb begin
    unique case (fn_i)
      ALU_ADD: res_o = b_i + a_i;
      ALU_SUB: res_o = b_i - a_i;
      ALU_AND: res_o = b_i & a_i;
      ALU_XOR: res_o = b_i ^ a_i;
      default: res_o = '0;
    endcase
  end

  // overflow: operands agree in sign (add) or differ (sub), result sign departs from b
  always_comb begin
    unique case (fn_i)
      ALU_ADD: ovf = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != b_i[MSB]);
      ALU_SUB: ovf = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != b_i[MSB]);
      default: ovf = 1'b0;
    endcase
  end

  assign cc_o.zf  = (res_o == '0);
  assign cc_o.sf  = res_o[MSB];
  assign cc_o.ovf = ovf;

endmodule

// File: rtl/exec_cond.sv
module exec_cond
  import exec_pkg::*;
(
  input  cc_t        cc_i,
  input  logic [3:0] fn_i,
  output logic       take_o
);

  logic lt;
  assign lt = cc_i.sf ^ cc_i.ovf;

  always_comb begin
    unique case (fn_i)
      4'd0:    take_o = 1'b1;
      4'd1:    take_o = lt | cc_i.zf;
      4'd2:    take_o = lt;
      4'd3:    take_o = cc_i.zf;
      4'd4:    take_o = !cc_i.zf;
      4'd5:    take_o = !lt;
      4'd6:    take_o = !lt && !cc_i.zf;
      default: take_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   opc_i,
  input  logic [3:0]   fn_i,
  input  logic [W-1:0] a_val_i,
  input  logic [W-1:0] b_val_i,
  input  logic [W-1:0] c_val_i,
  input  logic [W-1:0] p_val_i,
  input  logic [W-1:0] m_val_i,
  output logic [W-1:0] e_val_o,
  output logic         take_o,
  output logic [W-1:0] next_pc_o
);

  logic [W-1:0] alu_a, alu_b;
  alu_fn_e      alu_fn;
  logic         cc_we;
  cc_t          cc_d, cc_q;
  logic         cond_hit;

  exec_opsel #(.W(W)) u_opsel (
    .opc_i    (opc_i),
    .fn_i     (fn_i),
    .a_val_i  (a_val_i),
    .b_val_i  (b_val_i),
    .c_val_i  (c_val_i),
    .alu_a_o  (alu_a),
    .alu_b_o  (alu_b),
    .alu_fn_o (alu_fn),
    .cc_we_o  (cc_we)
  );

  exec_alu #(.W(W)) u_alu (
    .a_i   (alu_a),
    .b_i   (alu_b),
    .fn_i  (alu_fn),
    .res_o (e_val_o),
    .cc_o  (cc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cc_q <= CC_RESET;
    else if (cc_we) cc_q <= cc_d;
  end

  exec_cond u_cond (
    .cc_i   (cc_q),
    .fn_i   (fn_i),
    .take_o (cond_hit)
  );

  assign take_o = (opc_i == OP_JUMP) && cond_hit;

  always_comb begin
    if (opc_i == OP_CALL || take_o) next_pc_o = c_val_i;
    else if (opc_i == OP_RET)       next_pc_o = m_val_i;
    else                            next_pc_o = p_val_i;
  end

endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk
  import exec_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [3:0]   opc_i,
  input logic [3:0]   fn_i,
  input logic [W-1:0] a_val_i,
  input logic [W-1:0] b_val_i,
  input logic [W-1:0] c_val_i,
  input logic [W-1:0] p_val_i,
  input logic [W-1:0] m_val_i,
  input logic [W-1:0] e_val_o,
  input logic         take_o,
  input logic [W-1:0] next_pc_o,
  input cc_t          cc_i
);

  logic arith_ok;
  assign arith_ok = (opc_i == OP_ARITH) && (fn_i <= FN_ALU_MAX);

  assert_copy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc_i == OP_MOVRR) |-> (e_val_o == a_val_i));

  assert_push_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc_i == OP_PUSH) |-> (e_val_o == b_val_i - W'(W / 8)));

  assert_zero_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arith_ok && e_val_o == '0) |=> cc_i.zf);

  assert_sign_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arith_ok |=> (cc_i.sf == $past(e_val_o[W-1])));

  assert_flags_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arith_ok |=> $stable(cc_i));

  assert_take_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc_i != OP_JUMP) |-> !take_o);

  assert_jmp_always_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc_i == OP_JUMP && fn_i == 4'd0) |-> take_o);

  assert_call_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc_i == OP_CALL) |-> (next_pc_o == c_val_i));

  assert_ret_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc_i == OP_RET) |-> (next_pc_o == m_val_i));

endmodule

bind exec_unit exec_unit_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .opc_i     (opc_i),
  .fn_i      (fn_i),
  .a_val_i   (a_val_i),
  .b_val_i   (b_val_i),
  .c_val_i   (c_val_i),
  .p_val_i   (p_val_i),
  .m_val_i   (m_val_i),
  .e_val_o   (e_val_o),
  .take_o    (take_o),
  .next_pc_o (next_pc_o),
  .cc_i      (cc_q)
);

// File: tb/sim_exec_unit.sv
module sim_exec_unit;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   opc = 4'h0, fn = 4'h0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic [W-1:0] p = 32'h0000_0100, m = 32'h0000_0200;
  logic [W-1:0] e_val, next_pc;
  logic         take;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  exec_unit #(.W(W)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .opc_i     (opc),
    .fn_i      (fn),
    .a_val_i   (a),
    .b_val_i   (b),
    .c_val_i   (c),
    .p_val_i   (p),
    .m_val_i   (m),
    .e_val_o   (e_val),
    .take_o    (take),
    .next_pc_o (next_pc)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at falling edge, outputs settle before the next rising edge
  task automatic issue(input logic [3:0] o, input logic [3:0] f,
                       input logic [W-1:0] av, input logic [W-1:0] bv, input logic [W-1:0] cv);
    @(negedge clk);
    opc = o; fn = f; a = av; b = bv; c = cv;
    #1;
  endtask

  task automatic jmp_exp(input logic [3:0] f, input logic exp_take, input string tag);
    issue(4'h7, f, '0, '0, 32'h0000_0AAA);
    chk(tag, W'(take), W'(exp_take));
    chk(tag, next_pc, exp_take ? 32'h0000_0AAA : p);
  endtask

  task automatic t_reset;
    jmp_exp(4'd3, 1'b1, "R8 je after reset");
    jmp_exp(4'd4, 1'b0, "R8 jne after reset");
    jmp_exp(4'd2, 1'b0, "R8 jl after reset");
    jmp_exp(4'd6, 1'b0, "R8 jg after reset");
    jmp_exp(4'd1, 1'b1, "R8 jle after reset");
  endtask

  task automatic t_arith;
    issue(4'h6, 4'd0, 32'd5, 32'd7, '0);
    chk("R1 add", e_val, 32'd12);
    jmp_exp(4'd3, 1'b0, "R6 je after positive add");
    jmp_exp(4'd6, 1'b1, "R6 jg after positive add");
    issue(4'h6, 4'd1, 32'd5, 32'd3, '0);
    chk("R1 sub b-a", e_val, 32'hFFFF_FFFE);
    jmp_exp(4'd2, 1'b1, "R6 jl after negative sub");
    jmp_exp(4'd5, 1'b0, "R6 jge after negative sub");
    issue(4'h6, 4'd0, 32'd1, 32'h7FFF_FFFF, '0);
    chk("R1 add wrap", e_val, 32'h8000_0000);
    jmp_exp(4'd2, 1'b0, "R6 jl with S and O set");
    jmp_exp(4'd6, 1'b1, "R6 jg with S and O set");
    issue(4'h6, 4'd1, 32'd1, 32'h8000_0000, '0);
    chk("R1 sub wrap", e_val, 32'h7FFF_FFFF);
    jmp_exp(4'd2, 1'b1, "R6 jl with only O set");
    issue(4'h6, 4'd2, 32'h0000_000F, 32'h0000_00F0, '0);
    chk("R1 and", e_val, 32'h0);
    jmp_exp(4'd3, 1'b1, "R6 je after and to zero");
    issue(4'h6, 4'd3, 32'h0000_A5A5, 32'h0000_FFFF, '0);
    chk("R1 xor", e_val, 32'h0000_5A5A);
    jmp_exp(4'd4, 1'b1, "R6 jne after xor");
    jmp_exp(4'd1, 1'b0, "R6 jle after xor");
  endtask

  task automatic t_moves;
    issue(4'h2, 4'd0, 32'h1234, 32'h9999, 32'h7777);
    chk("R2 register copy", e_val, 32'h1234);
    issue(4'h3, 4'd0, 32'h1111, 32'h9999, 32'hCAFE);
    chk("R2 immediate", e_val, 32'hCAFE);
    issue(4'h4, 4'd0, 32'h5, 32'h100, 32'h20);
    chk("R3 store address", e_val, 32'h120);
    issue(4'h5, 4'd0, 32'h5, 32'h1000, 32'hFFFF_FFF8);
    chk("R3 load address", e_val, 32'hFF8);
    issue(4'hA, 4'd0, 32'h5, 32'h400, '0);
    chk("R4 push", e_val, 32'h3FC);
    issue(4'hB, 4'd0, 32'h5, 32'h400, '0);
    chk("R4 pop", e_val, 32'h404);
    issue(4'h8, 4'd0, 32'h5, 32'h400, 32'h0000_0C00);
    chk("R4 call", e_val, 32'h3FC);
    chk("R10 call target", next_pc, 32'h0000_0C00);
    issue(4'h9, 4'd0, 32'h5, 32'h400, 32'h0000_0C00);
    chk("R4 return", e_val, 32'h404);
    chk("R10 return target", next_pc, m);
    chk("R9 no take on return", W'(take), '0);
  endtask

  task automatic t_zero;
    issue(4'h0, 4'd0, 32'h5, 32'h6, 32'h7);
    chk("R5 nop", e_val, '0);
    issue(4'h1, 4'd0, 32'h5, 32'h6, 32'h7);
    chk("R5 halt", e_val, '0);
    issue(4'hC, 4'd0, 32'h5, 32'h6, 32'h7);
    chk("R5 undefined opcode", e_val, '0);
    chk("R10 fall through", next_pc, p);
    issue(4'h6, 4'd5, 32'h5, 32'h6, 32'h7);
    chk("R5 arith bad fn", e_val, '0);
    issue(4'h7, 4'd0, 32'h5, 32'h6, 32'h7);
    chk("R5 jump result", e_val, '0);
  endtask

  task automatic t_hold;
    issue(4'h6, 4'd1, 32'd9, 32'd9, '0);
    chk("R1 equal sub", e_val, '0);
    issue(4'hA, 4'd0, '0, 32'h10, '0);
    issue(4'hB, 4'd0, '0, 32'hFFFF_FFFC, '0);
    issue(4'h3, 4'd0, '0, '0, 32'h8000_0000);
    issue(4'h5, 4'd0, '0, 32'h8000_0000, 32'h8000_0000);
    issue(4'h6, 4'd7, 32'd1, 32'h8000_0000, '0);
    issue(4'h2, 4'd0, 32'h8000_0000, '0, '0);
    jmp_exp(4'd3, 1'b1, "R7 je still set after non-arith");
    jmp_exp(4'd2, 1'b0, "R7 jl still clear after non-arith");
  endtask

  task automatic t_jump;
    issue(4'h6, 4'd0, 32'd1, 32'd1, '0);
    chk("R1 add small", e_val, 32'd2);
    jmp_exp(4'd0, 1'b1, "R9 jmp");
    jmp_exp(4'd4, 1'b1, "R9 jne");
    jmp_exp(4'd3, 1'b0, "R9 je");
    jmp_exp(4'd1, 1'b0, "R9 jle");
    jmp_exp(4'd5, 1'b1, "R9 jge");
    jmp_exp(4'd7, 1'b0, "R9 fn 7");
    jmp_exp(4'd15, 1'b0, "R9 fn 15");
    issue(4'h2, 4'd0, 32'h1, '0, 32'h0000_0AAA);
    chk("R9 no take on copy", W'(take), '0);
    chk("R10 copy falls through", next_pc, p);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_arith();
    t_moves();
    t_zero();
    t_hold();
    t_jump();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule